// File: doc/BRIEF.md
# Nibble-Parallel Frame-Master Transmit Payload Port

This block takes transmit payload for an E3-rate framer from terminal equipment over a 4-bit parallel bus. It runs from a local bit-rate clock and divides that clock by four to make a nibble clock. The nibble clock goes out to the equipment, which launches one nibble on each of its rising edges. The block samples each nibble on a fixed bit-clock edge inside the nibble period. It then shifts the nibble out as a serial bit stream, one bit per bit-clock cycle, with a strobe that marks payload bits.

The block is the framing master. A free-running slot counter, clocked only by the local bit clock, divides the stream into frames of 1536 bits, or 384 nibble slots. It raises a one-cycle marker on the last serial bit of each frame. The first 12 bit positions of every frame are overhead. An early-warning output tells the equipment, one nibble period ahead, that the next nibble slot is overhead and that any data it puts on the bus for that slot will be dropped.

Top module: `nibtx_frame_master`

## Requirements
- R1: `nib_clk_o` is the bit clock divided by four. After reset it is high for two bit-clock cycles and low for two, and it rises every fourth cycle. The cycle right after reset is released is the first high cycle.
- R2: The nibble on `tx_nib_i` is sampled on the third rising bit-clock edge after the rising edge of `nib_clk_o`. The bus only has to hold the nibble during the two bit periods before that edge. Its value in the other two bit periods of the nibble period has no effect on the output.
- R3: Each sampled nibble appears on `bit_o` with bit 3 first, then bits 2, 1 and 0, one bit per cycle. The first bit is output in the cycle right after the sampling edge, so the stream has no gaps.
- R4: `bit_vld_o` is 1 for every payload bit. It is 0 for overhead bit positions and before the first nibble has been sampled after reset.
- R5: A frame is 1536 serial bits, or 384 nibble slots. Slots 0 to 2 (bits 0 to 11) are overhead. In those slots the bus is ignored and `bit_o` is 0.
- R6: `frame_end_o` is 1 for exactly one cycle, together with the last serial bit (bit 1535) of each frame. It therefore repeats every 1536 cycles.
- R7: `ovh_warn_o` is 1 for the whole nibble period whose following slot is overhead, that is, during slots 383, 0 and 1. It is 0 in all other slots.
- R8: Frame timing is free-running from the bit clock and has no synchronisation input. A synchronous active-high `rst` puts the divider at phase 0 and the slot counter at slot 0, and clears the serial output. After that, timing restarts exactly as it does after the first reset.
- R9: While `rst` is held, the outputs are `nib_clk_o`=1, `ovh_warn_o`=1, `bit_o`=0, `bit_vld_o`=0 and `frame_end_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_nib_i | input | 4 | Payload nibble from the terminal equipment |
| nib_clk_o | output | 1 | Nibble clock to the equipment (bit clock / 4) |
| ovh_warn_o | output | 1 | Next nibble slot is overhead |
| bit_o | output | 1 | Serialized payload bit |
| bit_vld_o | output | 1 | `bit_o` carries a payload bit |
| frame_end_o | output | 1 | Last bit of the current frame |

## Verification
The assertions check on every cycle that the nibble clock keeps its two-high, two-low shape and that the frame marker never lasts longer than one cycle. They also check that the marker only appears at the divider phase and slot where the last bit of a frame must land, that non-payload bits are always zero, and that the warning only starts in the last slot of a frame.

Only the bench scenarios can show the rest. These are the exact bit order of sampled nibbles and the choice of sampling edge, which the bench tests by putting junk on the bus outside the sampling window. They also include that overhead data is dropped, the 1536-cycle marker spacing, and a clean restart after a reset in mid-frame.

// File: rtl/nibtx_pkg.sv
package nibtx_pkg;

    // Bits carried by one nibble slot; also the bit-clock divide ratio.
    localparam int NIB_W = 4;

    // One serializer stage: shift data plus slot attributes.
    typedef struct packed {
        logic [NIB_W-1:0] sh;
        logic             ovh;
        logic             last;
    } ser_stage_t;

    // True when a nibble slot index falls inside the overhead region.
    function automatic logic slot_is_ovh(input int unsigned slot,
                                         input int unsigned n_ovh);
        return slot < n_ovh;
    endfunction

endpackage

// File: rtl/nibtx_clkdiv.sv
module nibtx_clkdiv #(
    parameter int DIV      = 4,
    parameter int CAP_EDGE = 3,
    localparam int PH_W    = $clog2(DIV)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph_o,
    output logic            nclk_o,
    output logic            cap_o,
    output logic            wrap_o
);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= '0;
        else if (ph_q == PH_W'(DIV - 1))
            ph_q <= '0;
        else
            ph_q <= ph_q + 1'b1;
    end

    assign ph_o   = ph_q;
    assign nclk_o = ph_q < PH_W'(DIV / 2);
    assign cap_o  = ph_q == PH_W'(CAP_EDGE - 1);
    assign wrap_o = ph_q == PH_W'(DIV - 1);

    // R1: nibble clock stays high two cycles after it rises, then drops
    a_r1_nclk_shape: assert property (@(posedge clk) disable iff (rst)
        $rose(nclk_o) |=> nclk_o ##1 !nclk_o);

endmodule

// File: rtl/nibtx_slot_ctr.sv
module nibtx_slot_ctr
    import nibtx_pkg::*;
#(
    parameter int SLOTS     = 384,
    parameter int OVH_SLOTS = 3,
    localparam int SLOT_W   = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              ovh_now_o,
    output logic              last_now_o,
    output logic              warn_o
);

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nxt;

    always_comb begin
        if (slot_q == SLOT_W'(SLOTS - 1))
            slot_nxt = '0;
        else
            slot_nxt = slot_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            slot_q <= '0;
        else if (adv_i)
            slot_q <= slot_nxt;
    end

    assign slot_o     = slot_q;
    assign ovh_now_o  = slot_is_ovh(32'(slot_q), OVH_SLOTS);
    assign last_now_o = slot_q == SLOT_W'(SLOTS - 1);
    assign warn_o     = slot_is_ovh(32'(slot_nxt), OVH_SLOTS);

    // R7: the warning can only begin in the final slot of a frame
    a_r7_warn_start: assert property (@(posedge clk) disable iff (rst)
        $rose(warn_o) |-> slot_q == SLOT_W'(SLOTS - 1));

endmodule

// File: rtl/nibtx_serializer.sv
module nibtx_serializer
    import nibtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [NIB_W-1:0] nib_i,
    input  logic             ovh_i,
    input  logic             last_i,
    output logic             bit_o,
    output logic             vld_o,
    output logic             end_o
);

    localparam int IDX_W = $clog2(NIB_W);

    ser_stage_t       st_q;
    logic [IDX_W-1:0] idx_q;
    logic             act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            idx_q <= '0;
            act_q <= 1'b0;
        end else if (load_i) begin
            st_q.sh   <= ovh_i ? '0 : nib_i;
            st_q.ovh  <= ovh_i;
            st_q.last <= last_i;
            idx_q     <= '0;
            act_q     <= 1'b1;
        end else begin
            st_q.sh <= {st_q.sh[NIB_W-2:0], 1'b0};
            idx_q   <= idx_q + 1'b1;
        end
    end

    assign bit_o = st_q.sh[NIB_W-1];
    assign vld_o = act_q & ~st_q.ovh;
    assign end_o = act_q & st_q.last & (idx_q == IDX_W'(NIB_W - 1));

    // R6: frame marker never lasts beyond one bit period
    a_r6_end_single: assert property (@(posedge clk) disable iff (rst)
        end_o |=> !end_o);

    // R5: every non-payload bit on the stream is zero
    a_r5_ovh_zero: assert property (@(posedge clk) disable iff (rst)
        !vld_o |-> !bit_o);

endmodule

// File: rtl/nibtx_frame_master.sv
module nibtx_frame_master
    import nibtx_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int OVH_BITS   = 12,
    parameter int CAP_EDGE   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] tx_nib_i,
    output logic             nib_clk_o,
    output logic             ovh_warn_o,
    output logic             bit_o,
    output logic             bit_vld_o,
    output logic             frame_end_o
);

    localparam int SLOTS     = FRAME_BITS / NIB_W;
    localparam int OVH_SLOTS = OVH_BITS / NIB_W;
    localparam int PH_W      = $clog2(NIB_W);
    localparam int SLOT_W    = $clog2(SLOTS);

    logic [PH_W-1:0]   ph;
    logic              cap;
    logic              wrap;
    logic [SLOT_W-1:0] slot;
    logic              ovh_now;
    logic              last_now;

    nibtx_clkdiv #(
        .DIV      (NIB_W),
        .CAP_EDGE (CAP_EDGE)
    ) div_i (
        .clk    (clk),
        .rst    (rst),
        .ph_o   (ph),
        .nclk_o (nib_clk_o),
        .cap_o  (cap),
        .wrap_o (wrap)
    );

    nibtx_slot_ctr #(
        .SLOTS     (SLOTS),
        .OVH_SLOTS (OVH_SLOTS)
    ) slot_i (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (wrap),
        .slot_o     (slot),
        .ovh_now_o  (ovh_now),
        .last_now_o (last_now),
        .warn_o     (ovh_warn_o)
    );

    nibtx_serializer ser_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (cap),
        .nib_i  (tx_nib_i),
        .ovh_i  (ovh_now),
        .last_i (last_now),
        .bit_o  (bit_o),
        .vld_o  (bit_vld_o),
        .end_o  (frame_end_o)
    );

    // R6: last frame bit lands in slot 0 at the sampling phase
    a_r6_end_align: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |-> (slot == '0) && (ph == PH_W'(CAP_EDGE - 1)));

endmodule

// File: tb/nibtx_frame_master_tb.sv
`timescale 1ns/1ps
module nibtx_frame_master_tb_top;

    localparam int SLOTS  = 384;
    localparam int FBITS  = 1536;
    localparam int NDAT   = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] tx_nib = 4'h0;
    logic       nib_clk, ovh_warn, bit_s, bit_vld, frame_end;

    int n_chk  = 0;
    int n_fail = 0;
    int last_end_k = -1;
    bit done = 1'b0;
    logic [3:0] dat [0:NDAT-1];

    always #10 clk = ~clk;

    nibtx_frame_master dut_i (
        .clk         (clk),
        .rst         (rst),
        .tx_nib_i    (tx_nib),
        .nib_clk_o   (nib_clk),
        .ovh_warn_o  (ovh_warn),
        .bit_o       (bit_s),
        .bit_vld_o   (bit_vld),
        .frame_end_o (frame_end)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp_v);
        end
    endtask

    function automatic int exp_nclk(input int k);
        return ((k % 4) < 2) ? 1 : 0;
    endfunction

    function automatic int exp_warn(input int k);
        int s;
        s = (k / 4) % SLOTS;
        return (s == SLOTS - 1 || s == 0 || s == 1) ? 1 : 0;
    endfunction

    // serial expectations: bit (0/1), valid, frame end
    function automatic int exp_bit(input int k);
        int s, j;
        if (k < 3) return 0;
        s = (k - 3) / 4;
        j = (k - 3) % 4;
        if ((s % SLOTS) < 3) return 0;
        return int'(dat[s][3 - j]);
    endfunction

    function automatic int exp_vld(input int k);
        if (k < 3) return 0;
        return ((((k - 3) / 4) % SLOTS) < 3) ? 0 : 1;
    endfunction

    function automatic int exp_end(input int k);
        if (k < 3) return 0;
        return (((((k - 3) / 4) % SLOTS) == SLOTS - 1) && (((k - 3) % 4) == 3)) ? 1 : 0;
    endfunction

    task automatic fill(input int mode);
        for (int i = 0; i < NDAT; i++) dat[i] = 4'($urandom);
        // directed corner nibbles in the first payload slots
        dat[3] = 4'hF; dat[4] = 4'h0; dat[5] = 4'hA; dat[6] = 4'h5;
        dat[7] = (mode == 0) ? 4'h8 : 4'h1;
        // overhead slots of the second frame carry data that must be dropped
        dat[SLOTS] = 4'hF; dat[SLOTS + 1] = 4'hF; dat[SLOTS + 2] = 4'hF;
    endtask

    task automatic chk_reset_state();
        chk("R9 nib_clk", int'(nib_clk), 1);
        chk("R9 ovh_warn", int'(ovh_warn), 1);
        chk("R9 bit", int'(bit_s), 0);
        chk("R9 bit_vld", int'(bit_vld), 0);
        chk("R9 frame_end", int'(frame_end), 0);
    endtask

    // at a falling edge with k rising edges since reset release
    task automatic run(input int n);
        last_end_k = -1;
        for (int k = 0; k < n; k++) begin
            chk("R1 nib_clk", int'(nib_clk), exp_nclk(k));
            chk("R7 ovh_warn", int'(ovh_warn), exp_warn(k));
            chk("R2/R3/R5 bit", int'(bit_s), exp_bit(k));
            chk("R4 bit_vld", int'(bit_vld), exp_vld(k));
            chk("R6 frame_end", int'(frame_end), exp_end(k));
            if (frame_end) begin
                if (last_end_k >= 0) chk("R6 spacing", k - last_end_k, FBITS);
                last_end_k = k;
            end
            // R2: valid data only in the two bit periods before the sampling edge
            if ((k % 4) == 1 || (k % 4) == 2) tx_nib = dat[k / 4];
            else tx_nib = 4'($urandom);
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd24680));
        fill(0);
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk_reset_state();
        rst = 1'b0;
        run(2 * FBITS + 100);
        // R8: mid-frame reset restarts timing from slot 0
        fill(1);
        rst = 1'b1;
        tx_nib = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_reset_state();
        rst = 1'b0;
        run(FBITS + 60);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule